// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programmable address and length state of a four-channel DMA controller. For each channel it keeps a 16-bit start address, a 16-bit transfer length, a working copy of the start address, and a progress counter fed by the transfer engine. The CPU reaches all of it through one byte-wide port. Because the registers are 16 bits wide and the port is 8, a single byte pointer shared by every channel decides whether each access touches the low byte or the high byte. The pointer flips after every access, whether read or write.

Writing the high byte of either register of a channel arms that channel. Its working address is loaded from the start address and its progress counter returns to zero. A readback shows live values: the address register returns the working address moved by the progress so far, upward or downward, and the count register returns how much of the programmed length is still left. A word-mode parameter lets the same block serve a 16-bit controller. In word mode the port address is taken one bit higher, stored addresses are in bytes (twice the word address), and progress advances two bytes per strobe.

Top module: `dma_chan_regs`

## Requirements
- R1: The 4-bit port index is taken from addr_i starting at bit WORD_SHIFT. Index bits [3:1] give the channel and bit 0 gives the register (0 = address, 1 = count). A channel number of NUM_CH or more writes nothing and reads as 0x00, but still toggles the byte pointer.
- R2: Every accepted access (acc_i high at a clock edge), read or write, inverts the byte pointer ptr_o. The pointer holds when there is no access. When ptr_o is 0 an access uses bits [7:0]; when it is 1 the access uses bits [15:8].
- R3: A write with ptr_o = 0 changes only the low byte of the selected base register. The working address and the progress of the channel are left as they were.
- R4: A write with ptr_o = 1 sets the high byte of the selected base register. In the same edge it loads the working address with the base address (including the new byte) shifted left by WORD_SHIFT, and it clears the progress to zero.
- R5: rdata_o for the count register is byte ptr_o of ((base_count << WORD_SHIFT) - progress), taken modulo 2^(16+WORD_SHIFT) and then shifted right by WORD_SHIFT.
- R6: rdata_o for the address register is byte ptr_o of (working address + progress), or (working address - progress) when dir_down_i of that channel is 1. The value is taken modulo 2^(16+WORD_SHIFT) and then shifted right by WORD_SHIFT. Readback is combinational.
- R7: ff_clr_i forces ptr_o to 0 at the next edge and wins over an access in the same cycle. That access still uses the pointer value it saw.
- R8: Each inc_i strobe adds 2^WORD_SHIFT to that channel's progress, which stops at (base_count + 1) << WORD_SHIFT. tc_o of a channel is high exactly while its progress equals that limit.
- R9: Reset (rst_ni low, asynchronous) clears every base register, working address and progress counter, and sets ptr_o to 0.
- R10: When a high-byte write and an inc_i strobe hit the same channel in the same cycle, the progress ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Port access strobe, one per cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Port address; index at bits [WORD_SHIFT+3:WORD_SHIFT] |
| wdata_i | input | 8 | Write byte |
| ff_clr_i | input | 1 | Clears the byte pointer |
| dir_down_i | input | NUM_CH | Per-channel address direction, 1 = decrement |
| inc_i | input | NUM_CH | Per-channel progress strobe from the transfer engine |
| rdata_o | output | 8 | Readback byte for the current index and pointer |
| ptr_o | output | 1 | Byte pointer state |
| tc_o | output | NUM_CH | Per-channel progress-at-limit flag |

## Verification
The hardest states to reach are those where several edge conditions line up. One is a channel sitting at its progress limit, so that the count reads back as a negative wrap while the address reads back in the down direction. Another is a pointer clear arriving in the same cycle as a high-byte write, and a third is an arming write colliding with a progress strobe. The stimulus drives the progress strobes past the limit before switching direction. It then issues the clear and the colliding strobe in the same cycle as the accesses. An 8-bit and a 16-bit instance run the same sequence side by side, and a behavioural model checks both after every clock.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic {
    REG_ADDR  = 1'b0,
    REG_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 5,
  parameter int WORD_SHIFT = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              acc_i,
  input  logic              wr_i,
  output logic [2:0]        ch_o,
  output reg_sel_e          reg_o,
  output logic              hit_o,
  output logic [NUM_CH-1:0] wr_sel_o
);
  logic [IDX_W-1:0] idx;

  assign idx   = addr_i[WORD_SHIFT +: IDX_W];
  assign ch_o  = idx[3:1];
  assign reg_o = reg_sel_e'(idx[0]);
  assign hit_o = (32'(ch_o) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign wr_sel_o[i] = acc_i & wr_i & (ch_o == 3'(i));
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic clr_i,
  output logic ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= 1'b0;
    else if (clr_i)  ptr_o <= 1'b0;
    else if (acc_i)  ptr_o <= ~ptr_o;
  end

  a_r2_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !clr_i |=> ptr_o != $past(ptr_o));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i && !clr_i |=> $stable(ptr_o));
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ptr_o);
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int WORD_SHIFT = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  reg_sel_e                     reg_i,
  input  logic                         hi_i,
  input  logic [BYTE_W-1:0]            wdata_i,
  input  logic                         inc_i,
  input  logic                         dir_down_i,
  output logic [WORD_W+WORD_SHIFT-1:0] addr_val_o,
  output logic [WORD_W+WORD_SHIFT-1:0] cnt_val_o,
  output logic                         tc_o
);
  localparam int CA_W  = WORD_W + WORD_SHIFT;
  localparam int PW    = WORD_W + 1 + WORD_SHIFT;
  localparam int VAL_W = WORD_W + WORD_SHIFT;

  logic [WORD_W-1:0] base_addr_q, base_cnt_q, base_addr_d, base_cnt_d;
  logic [CA_W-1:0]   cur_addr_q;
  logic [PW-1:0]     prog_q, prog_d, limit, prog_bump;
  logic              reload;

  assign reload = wr_en_i & hi_i;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_en_i) begin
      if (reg_i == REG_ADDR) begin
        if (hi_i) base_addr_d[15:8] = wdata_i;
        else      base_addr_d[7:0]  = wdata_i;
      end else begin
        if (hi_i) base_cnt_d[15:8] = wdata_i;
        else      base_cnt_d[7:0]  = wdata_i;
      end
    end
  end

  assign limit     = PW'({1'b0, base_cnt_q} + 17'd1) << WORD_SHIFT;
  assign prog_bump = prog_q + PW'(1 << WORD_SHIFT);

  always_comb begin
    if (reload)      prog_d = '0;
    else if (inc_i)  prog_d = (prog_bump >= limit) ? limit : prog_bump;
    else             prog_d = prog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      prog_q      <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      prog_q      <= prog_d;
      if (reload) cur_addr_q <= CA_W'(base_addr_d) << WORD_SHIFT;
    end
  end

  assign addr_val_o = dir_down_i ? (VAL_W'(cur_addr_q) - VAL_W'(prog_q))
                                 : (VAL_W'(cur_addr_q) + VAL_W'(prog_q));
  assign cnt_val_o  = (VAL_W'(base_cnt_q) << WORD_SHIFT) - VAL_W'(prog_q);
  assign tc_o       = (prog_q == limit);

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (prog_q == '0) && (cur_addr_q == (CA_W'(base_addr_q) << WORD_SHIFT)));
  a_r3_low_keeps_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !hi_i |=> $stable(cur_addr_q));
  a_r10_reload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload && inc_i |=> prog_q == '0);
  a_r8_hold_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && inc_i && !wr_en_i |=> $stable(prog_q) && tc_o);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 5,
  parameter int WORD_SHIFT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              ff_clr_i,
  input  logic [NUM_CH-1:0] dir_down_i,
  input  logic [NUM_CH-1:0] inc_i,
  output logic [7:0]        rdata_o,
  output logic              ptr_o,
  output logic [NUM_CH-1:0] tc_o
);
  localparam int VAL_W = WORD_W + WORD_SHIFT;

  logic [2:0]        ch;
  reg_sel_e          reg_sel;
  logic              hit;
  logic [NUM_CH-1:0] wr_sel;
  logic [VAL_W-1:0]  addr_val [NUM_CH];
  logic [VAL_W-1:0]  cnt_val  [NUM_CH];
  logic [VAL_W-1:0]  sel_val;

  dma_port_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)
  ) u_decode (
    .addr_i(addr_i), .acc_i(acc_i), .wr_i(wr_i),
    .ch_o(ch), .reg_o(reg_sel), .hit_o(hit), .wr_sel_o(wr_sel)
  );

  dma_byte_ptr u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .clr_i(ff_clr_i), .ptr_o(ptr_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan_slot #(.WORD_SHIFT(WORD_SHIFT)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_sel[i]), .reg_i(reg_sel), .hi_i(ptr_o), .wdata_i(wdata_i),
      .inc_i(inc_i[i]), .dir_down_i(dir_down_i[i]),
      .addr_val_o(addr_val[i]), .cnt_val_o(cnt_val[i]), .tc_o(tc_o[i])
    );
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch == 3'(i)) sel_val = (reg_sel == REG_COUNT) ? cnt_val[i] : addr_val[i];
    end
  end

  always_comb begin
    if (!hit)       rdata_o = '0;
    else if (ptr_o) rdata_o = sel_val[WORD_SHIFT+8 +: 8];
    else            rdata_o = sel_val[WORD_SHIFT +: 8];
  end

  a_r1_no_write_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && wr_i && !hit |=> $stable(tc_o));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni, acc, wr, clr;
  logic [3:0] idx, dir, inc;
  logic [7:0] wd;
  logic [7:0] rd0, rd1;
  logic       p0, p1;
  logic [3:0] tc0, tc1;
  logic [4:0] a0, a1;
  assign a0 = {1'b0, idx};
  assign a1 = {idx, 1'b0};

  dma_chan_regs #(.NUM_CH(4), .ADDR_W(5), .WORD_SHIFT(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_i(acc), .wr_i(wr), .addr_i(a0), .wdata_i(wd),
    .ff_clr_i(clr), .dir_down_i(dir), .inc_i(inc), .rdata_o(rd0), .ptr_o(p0), .tc_o(tc0));
  dma_chan_regs #(.NUM_CH(4), .ADDR_W(5), .WORD_SHIFT(1)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_ni), .acc_i(acc), .wr_i(wr), .addr_i(a1), .wdata_i(wd),
    .ff_clr_i(clr), .dir_down_i(dir), .inc_i(inc), .rdata_o(rd1), .ptr_o(p1), .tc_o(tc1));

  int errs = 0, checks = 0;
  bit done = 0;
  int ba[2][4], bc[2][4], ca[2][4], pg[2][4];
  int pt[2];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rd(int k);
    int ch, v;
    ch = int'(idx[3:1]);
    if (ch >= 4) return 0;
    if (idx[0]) v = (bc[k][ch] << k) - pg[k][ch];
    else        v = dir[ch] ? ca[k][ch] - pg[k][ch] : ca[k][ch] + pg[k][ch];
    return (v >> (k + (pt[k] != 0 ? 8 : 0))) & 255;
  endfunction

  function automatic int exp_tc(int k);
    int r = 0;
    for (int c = 0; c < 4; c++)
      if (pg[k][c] == ((bc[k][c] + 1) << k)) r |= (1 << c);
    return r;
  endfunction

  task automatic cmp(string tag);
    chk(tag, "rdata8",  32'(rd0), 32'(exp_rd(0)));
    chk(tag, "rdata16", 32'(rd1), 32'(exp_rd(1)));
    chk(tag, "ptr8",    32'(p0),  32'(pt[0]));
    chk(tag, "ptr16",   32'(p1),  32'(pt[1]));
    chk(tag, "tc8",     32'(tc0), 32'(exp_tc(0)));
    chk(tag, "tc16",    32'(tc1), 32'(exp_tc(1)));
  endtask

  task automatic model_edge();
    int ch, np, lim;
    ch = int'(idx[3:1]);
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        lim = (bc[k][c] + 1) << k;
        np  = pg[k][c];
        if (inc[c]) begin
          np = np + (1 << k);
          if (np > lim) np = lim;
        end
        if (acc && wr && ch == c) begin
          if (pt[k] == 0) begin
            if (idx[0]) bc[k][c] = (bc[k][c] & 32'hFF00) | int'(wd);
            else        ba[k][c] = (ba[k][c] & 32'hFF00) | int'(wd);
          end else begin
            if (idx[0]) bc[k][c] = (bc[k][c] & 32'h00FF) | (int'(wd) << 8);
            else        ba[k][c] = (ba[k][c] & 32'h00FF) | (int'(wd) << 8);
            ca[k][c] = ba[k][c] << k;
            np = 0;
          end
        end
        pg[k][c] = np;
      end
      if (clr)      pt[k] = 0;
      else if (acc) pt[k] = 1 - pt[k];
    end
  endtask

  task automatic step(bit a, bit w, logic [3:0] i, logic [7:0] d, bit c,
                      logic [3:0] n, string tag);
    acc = a; wr = w; idx = i; wd = d; clr = c; inc = n;
    #1 cmp(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    acc = 0; clr = 0; inc = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      pt[k] = 0;
      for (int c = 0; c < 4; c++) begin ba[k][c] = 0; bc[k][c] = 0; ca[k][c] = 0; pg[k][c] = 0; end
    end
    rst_ni = 0; acc = 0; wr = 0; idx = 0; wd = 0; clr = 0; inc = 0; dir = 0;
    @(negedge clk); @(negedge clk);
    #1 cmp("R9");
    rst_ni = 1;
    @(negedge clk);

    // R3/R4 program channel 1
    step(1, 1, 4'h2, 8'h34, 0, 4'h0, "R3");
    step(1, 1, 4'h2, 8'h12, 0, 4'h0, "R4");
    step(1, 1, 4'h3, 8'h03, 0, 4'h0, "R3");
    step(1, 1, 4'h3, 8'h00, 0, 4'h0, "R4");
    // R6 readback, R2 toggling on reads
    step(0, 0, 4'h2, 8'h00, 0, 4'h0, "R6");
    step(1, 0, 4'h2, 8'h00, 0, 4'h0, "R6");
    step(1, 0, 4'h2, 8'h00, 0, 4'h0, "R2");
    // R8 progress to saturation
    for (int j = 0; j < 6; j++) step(0, 0, 4'h3, 8'h00, 0, 4'b0010, "R8");
    step(1, 0, 4'h3, 8'h00, 0, 4'h0, "R5");
    step(1, 0, 4'h3, 8'h00, 0, 4'h0, "R5");
    dir = 4'b0010;
    step(1, 0, 4'h2, 8'h00, 0, 4'h0, "R6");
    step(1, 0, 4'h2, 8'h00, 0, 4'h0, "R6");
    // R7 pointer clear
    step(1, 1, 4'h0, 8'hAA, 0, 4'h0, "R7");
    step(0, 0, 4'h0, 8'h00, 1, 4'h0, "R7");
    step(1, 1, 4'h0, 8'h55, 0, 4'h0, "R7");
    step(1, 1, 4'h0, 8'h66, 1, 4'h0, "R7");
    step(1, 1, 4'h0, 8'h77, 0, 4'h0, "R7");
    step(1, 0, 4'h0, 8'h00, 0, 4'h0, "R7");
    step(1, 0, 4'h0, 8'h00, 0, 4'h0, "R7");
    // R1 out-of-range channel
    step(1, 1, 4'h8, 8'h99, 0, 4'h0, "R1");
    step(1, 1, 4'h9, 8'h99, 0, 4'h0, "R1");
    step(0, 0, 4'h8, 8'h00, 0, 4'h0, "R1");
    step(0, 0, 4'h0, 8'h00, 0, 4'h0, "R1");
    step(1, 1, 4'h7, 8'hF0, 0, 4'h0, "R1");
    step(1, 1, 4'h7, 8'h01, 0, 4'h0, "R1");
    step(0, 0, 4'h7, 8'h00, 0, 4'h0, "R1");
    // R10 reload collides with a strobe
    step(1, 1, 4'h2, 8'h00, 0, 4'b0010, "R10");
    step(1, 1, 4'h2, 8'h20, 0, 4'b0010, "R10");
    step(0, 0, 4'h3, 8'h00, 0, 4'h0, "R10");
    // R2 a read moves the pointer so the next write hits the high byte
    step(1, 0, 4'h6, 8'h00, 0, 4'h0, "R2");
    step(1, 1, 4'h6, 8'hC4, 0, 4'h0, "R2");
    step(0, 0, 4'h6, 8'h00, 0, 4'h0, "R2");
    // R8 all channels, mixed directions
    dir = 4'b0101;
    for (int j = 0; j < 5; j++) step(0, 0, 4'(2 * (j % 4)), 8'h00, 0, 4'b1111, "R8");
    step(1, 0, 4'h1, 8'h00, 0, 4'h0, "R5");
    step(1, 0, 4'h1, 8'h00, 0, 4'h0, "R5");
    step(0, 0, 4'h4, 8'h00, 0, 4'h0, "R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule